// File: doc/BRIEF.md
# Network Adapter Command and Status Engine

This block is the host-facing control point of a network adapter. The host writes 16-bit command words to one port. Each word holds a 5-bit opcode and an 11-bit argument. The block then updates its internal state. That state is a 3-bit register-window number, the receive and transmit enables, eight event/status bits, an interrupt-enable mask and a read-visibility mask. Events from the receive, transmit and statistics logic arrive as single-cycle pulses. They set status bits, and those bits raise the interrupt when the enable mask allows it.

The host reads a 16-bit status word at any time. It carries the window number in the top three bits and a busy flag in bit 12. The event bits sit in the low byte, filtered by the visibility mask. Reset-type commands and commands aimed at logic outside this block leave as one-cycle strobes. After a reset-type command, the busy flag stays high for a fixed number of cycles, and commands written during that time are dropped.

Top module: `nic_cmd_status`

## Requirements
- R1: A command word holds the opcode in bits 15..11 and the argument in bits 10..0. Opcode 1 loads the window number from argument bits 2..0; the other argument bits have no effect.
- R2: Status bits 15..13 always show the current window number. Bits 11..8 read as zero.
- R3: Event pulses set status bits at fixed positions: adapter failure bit 1, TX complete bit 2, TX available bit 3, RX complete bit 4, RX early bit 5, statistics update bit 7. Opcode 0x0C sets bit 6 (interrupt requested). A set bit stays set until it is cleared.
- R4: Opcode 0x0D clears every status bit 0..7 whose matching argument bit is 1. All other bits keep their values.
- R5: Bit 0 (interrupt latch) is set whenever any of bits 1..7 is set while its interrupt-enable bit is also set. Opcode 0x0E loads the enable mask from argument bits 7..0. The `irq` output equals bit 0. Only an acknowledge of bit 0 clears the latch, and only when no enabled event remains.
- R6: Opcode 0x0F loads the visibility mask from argument bits 7..0. A status bit 0..7 whose mask bit is 0 reads as 0, but it keeps its stored value. The mask is all ones after reset.
- R7: Receive and transmit are both disabled after reset. Opcodes 4 and 3 enable and disable receive; opcodes 9 and 10 enable and disable transmit.
- R8: Opcode 0 (global reset), 5 (RX reset) and 0x0B (TX reset) each give a one-cycle strobe and hold status bit 12 high for BUSY_CYCLES cycles. RX reset disables receive and TX reset disables transmit. Global reset returns the window, enables, masks and status bits to their reset values.
- R9: A command written while status bit 12 is high has no effect.
- R10: When an event pulse and an acknowledge of the same bit come in the same cycle, the bit ends up set.
- R11: Every other opcode (2, 6, 7, 8, 0x10 to 0x1F) gives a one-cycle `fwd_stb`, with `fwd_op` and `fwd_arg` holding the opcode and the argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command word: opcode and argument |
| ev_fail | input | 1 | Adapter failure event pulse |
| ev_tx_done | input | 1 | Transmit complete event pulse |
| ev_tx_room | input | 1 | Transmit space available event pulse |
| ev_rx_done | input | 1 | Receive complete event pulse |
| ev_rx_early | input | 1 | Receive early threshold event pulse |
| ev_stats | input | 1 | Statistics update event pulse |
| status_word | output | 16 | Status word read by the host |
| irq | output | 1 | Interrupt request |
| rx_enabled | output | 1 | Receive path enable |
| tx_enabled | output | 1 | Transmit path enable |
| glob_rst_stb | output | 1 | Global reset strobe |
| rx_rst_stb | output | 1 | Receive reset strobe |
| tx_rst_stb | output | 1 | Transmit reset strobe |
| fwd_stb | output | 1 | Forwarded-command strobe |
| fwd_op | output | 5 | Opcode of the forwarded command |
| fwd_arg | output | 11 | Argument of the forwarded command |

## Verification
The hardest case to reach is an event pulse and an acknowledge of the same bit in the same clock cycle. This can only happen when the bench drives an event line and a command write on the same clock edge. The bench therefore drives both from one task at one falling edge, and then reads back the status bit and the latch. The next hardest case is the busy window. Here the bench issues a reset-type command, sends a window-select command while bit 12 is still high, and counts how many samples have bit 12 set. It then shows that the window did not change.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

    localparam int OP_W  = 5;
    localparam int ARG_W = 11;
    localparam int WIN_W = 3;
    localparam int EV_W  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_GLOB_RST = 5'h00,
        OP_WIN_SEL  = 5'h01,
        OP_RX_OFF   = 5'h03,
        OP_RX_ON    = 5'h04,
        OP_RX_RST   = 5'h05,
        OP_TX_ON    = 5'h09,
        OP_TX_OFF   = 5'h0A,
        OP_TX_RST   = 5'h0B,
        OP_REQ_INT  = 5'h0C,
        OP_ACK      = 5'h0D,
        OP_IEN_LD   = 5'h0E,
        OP_VIS_LD   = 5'h0F
    } op_e;

    typedef struct packed {
        logic              glob_rst;
        logic              win_sel;
        logic              rx_on;
        logic              rx_off;
        logic              rx_rst;
        logic              tx_on;
        logic              tx_off;
        logic              tx_rst;
        logic              req_int;
        logic              ack;
        logic              ien_ld;
        logic              vis_ld;
        logic              fwd;
        logic [OP_W-1:0]   op;
        logic [ARG_W-1:0]  arg;
    } cmd_act_t;

endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
    import nic_cmd_pkg::*;
(
    input  logic        accept,
    input  logic [15:0] cmd_word,
    output cmd_act_t    act
);
    logic [OP_W-1:0] op;
    assign op = cmd_word[15:11];

    always_comb begin
        act        = '0;
        act.op     = op;
        act.arg    = cmd_word[ARG_W-1:0];
        if (accept) begin
            case (op)
                OP_GLOB_RST: act.glob_rst = 1'b1;
                OP_WIN_SEL:  act.win_sel  = 1'b1;
                OP_RX_OFF:   act.rx_off   = 1'b1;
                OP_RX_ON:    act.rx_on    = 1'b1;
                OP_RX_RST:   act.rx_rst   = 1'b1;
                OP_TX_ON:    act.tx_on    = 1'b1;
                OP_TX_OFF:   act.tx_off   = 1'b1;
                OP_TX_RST:   act.tx_rst   = 1'b1;
                OP_REQ_INT:  act.req_int  = 1'b1;
                OP_ACK:      act.ack      = 1'b1;
                OP_IEN_LD:   act.ien_ld   = 1'b1;
                OP_VIS_LD:   act.vis_ld   = 1'b1;
                default:     act.fwd      = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/nic_evt_status.sv
module nic_evt_status
    import nic_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [EV_W-1:0] set_bits,
    input  logic            ack_en,
    input  logic            ien_ld,
    input  logic            vis_ld,
    input  logic [EV_W-1:0] mask_arg,
    output logic [EV_W-1:0] stat_bits,
    output logic [EV_W-1:0] vis_mask
);
    typedef struct packed {
        logic [EV_W-1:0] ev;
        logic [EV_W-1:0] ien;
        logic [EV_W-1:0] vis;
    } st_t;

    st_t st_d, st_q;
    logic [EV_W-1:0] ack_bits;
    logic [EV_W-1:1] ev_next;
    logic            latch_next;

    always_comb begin
        st_d     = st_q;
        ack_bits = ack_en ? mask_arg : '0;
        if (clr) begin
            st_d.ien = '0;
            st_d.vis = '1;
            ev_next  = set_bits[EV_W-1:1];
        end else begin
            if (ien_ld) st_d.ien = mask_arg;
            if (vis_ld) st_d.vis = mask_arg;
            // event pulses take priority over a clearing acknowledge
            ev_next = (st_q.ev[EV_W-1:1] & ~ack_bits[EV_W-1:1]) | set_bits[EV_W-1:1];
        end
        latch_next = (clr ? 1'b0 : (st_q.ev[0] & ~ack_bits[0]))
                   | (|(ev_next & st_d.ien[EV_W-1:1]));
        st_d.ev = {ev_next, latch_next};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ev  <= '0;
            st_q.ien <= '0;
            st_q.vis <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_bits = st_q.ev;
    assign vis_mask  = st_q.vis;

    assert_latch_covers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ev[EV_W-1:1] & st_q.ien[EV_W-1:1]) != '0) |-> st_q.ev[0]);

    assert_event_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits[EV_W-1:1] != '0) |=>
            ((st_q.ev[EV_W-1:1] & $past(set_bits[EV_W-1:1])) == $past(set_bits[EV_W-1:1])));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && !clr && set_bits == '0 && mask_arg[1] ) |=> !st_q.ev[1]);
endmodule

// File: rtl/nic_cmd_status.sv
module nic_cmd_status
    import nic_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [15:0] cmd_word,
    input  logic        ev_fail,
    input  logic        ev_tx_done,
    input  logic        ev_tx_room,
    input  logic        ev_rx_done,
    input  logic        ev_rx_early,
    input  logic        ev_stats,
    output logic [15:0] status_word,
    output logic        irq,
    output logic        rx_enabled,
    output logic        tx_enabled,
    output logic        glob_rst_stb,
    output logic        rx_rst_stb,
    output logic        tx_rst_stb,
    output logic        fwd_stb,
    output logic [4:0]  fwd_op,
    output logic [10:0] fwd_arg
);
    localparam int BCW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BCW-1:0] BUSY_LOAD = BCW'(BUSY_CYCLES);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             rx_en;
        logic             tx_en;
        logic [BCW-1:0]   busy_cnt;
        logic             glob_stb;
        logic             rxr_stb;
        logic             txr_stb;
        logic             fwd_stb;
        logic [OP_W-1:0]  fwd_op;
        logic [ARG_W-1:0] fwd_arg;
    } top_st_t;

    top_st_t st_d, st_q;
    cmd_act_t act;
    logic busy, accept;
    logic [EV_W-1:0] set_bits, stat_bits, vis_mask;

    assign busy   = (st_q.busy_cnt != '0);
    assign accept = cmd_we && !busy;

    nic_cmd_decode u_dec (
        .accept   (accept),
        .cmd_word (cmd_word),
        .act      (act)
    );

    assign set_bits = {ev_stats, act.req_int, ev_rx_early, ev_rx_done,
                       ev_tx_room, ev_tx_done, ev_fail, 1'b0};

    nic_evt_status u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (act.glob_rst),
        .set_bits  (set_bits),
        .ack_en    (act.ack),
        .ien_ld    (act.ien_ld),
        .vis_ld    (act.vis_ld),
        .mask_arg  (act.arg[EV_W-1:0]),
        .stat_bits (stat_bits),
        .vis_mask  (vis_mask)
    );

    always_comb begin
        st_d          = st_q;
        st_d.glob_stb = act.glob_rst;
        st_d.rxr_stb  = act.rx_rst;
        st_d.txr_stb  = act.tx_rst;
        st_d.fwd_stb  = act.fwd;
        if (act.fwd) begin
            st_d.fwd_op  = act.op;
            st_d.fwd_arg = act.arg;
        end
        if (busy) st_d.busy_cnt = st_q.busy_cnt - 1'b1;
        if (act.glob_rst || act.rx_rst || act.tx_rst) st_d.busy_cnt = BUSY_LOAD;
        if (act.win_sel) st_d.win = act.arg[WIN_W-1:0];
        if (act.rx_on)  st_d.rx_en = 1'b1;
        if (act.rx_off || act.rx_rst) st_d.rx_en = 1'b0;
        if (act.tx_on)  st_d.tx_en = 1'b1;
        if (act.tx_off || act.tx_rst) st_d.tx_en = 1'b0;
        if (act.glob_rst) begin
            st_d.win   = '0;
            st_d.rx_en = 1'b0;
            st_d.tx_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_word  = {st_q.win, busy, 4'b0000, stat_bits & vis_mask};
    assign irq          = stat_bits[0];
    assign rx_enabled   = st_q.rx_en;
    assign tx_enabled   = st_q.tx_en;
    assign glob_rst_stb = st_q.glob_stb;
    assign rx_rst_stb   = st_q.rxr_stb;
    assign tx_rst_stb   = st_q.txr_stb;
    assign fwd_stb      = st_q.fwd_stb;
    assign fwd_op       = st_q.fwd_op;
    assign fwd_arg      = st_q.fwd_arg;

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && status_word[12]) |=>
            ($stable(status_word[15:13]) && $stable(rx_enabled) && $stable(tx_enabled)));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({glob_rst_stb, rx_rst_stb, tx_rst_stb, fwd_stb}));

    assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_stb |=> !fwd_stb);

    assert_busy_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_rst_stb || rx_rst_stb || tx_rst_stb) |-> status_word[12]);
endmodule

// File: tb/nic_cmd_status_test.sv
`timescale 1ns/1ps
module nic_cmd_status_test;
    localparam int BUSY = 4;
    localparam int NV   = 15;
    // {cmd, expected status, irq, rx_enabled, tx_enabled}
    localparam logic [34:0] VEC [NV] = '{
        {16'h0805, 16'hA000, 3'b000},  // R1 R2 window 5
        {16'h6000, 16'hA040, 3'b000},  // R3 request interrupt
        {16'h7040, 16'hA041, 3'b100},  // R5 enable bit6 sets latch
        {16'h6840, 16'hA001, 3'b100},  // R4 ack bit6, latch stays
        {16'h6801, 16'hA000, 3'b000},  // R5 ack latch
        {16'h6000, 16'hA041, 3'b100},  // R5 request again
        {16'h7800, 16'hA000, 3'b100},  // R6 hide all
        {16'h78FF, 16'hA041, 3'b100},  // R6 show again
        {16'h6841, 16'hA000, 3'b000},  // R4 ack both
        {16'h0807, 16'hE000, 3'b000},  // R2 window 7
        {16'h08FB, 16'h6000, 3'b000},  // R1 extra arg bits ignored
        {16'h2000, 16'h6000, 3'b010},  // R7 rx on
        {16'h4800, 16'h6000, 3'b011},  // R7 tx on
        {16'h1800, 16'h6000, 3'b001},  // R7 rx off
        {16'h5000, 16'h6000, 3'b000}   // R7 tx off
    };

    logic clk = 0, rst_n = 0, cmd_we = 0;
    logic [15:0] cmd_word = 0;
    logic ev_fail = 0, ev_tx_done = 0, ev_tx_room = 0, ev_rx_done = 0, ev_rx_early = 0, ev_stats = 0;
    logic [15:0] status_word;
    logic irq, rx_enabled, tx_enabled, glob_rst_stb, rx_rst_stb, tx_rst_stb, fwd_stb;
    logic [4:0] fwd_op;
    logic [10:0] fwd_arg;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    nic_cmd_status #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .ev_fail(ev_fail), .ev_tx_done(ev_tx_done), .ev_tx_room(ev_tx_room),
        .ev_rx_done(ev_rx_done), .ev_rx_early(ev_rx_early), .ev_stats(ev_stats),
        .status_word(status_word), .irq(irq), .rx_enabled(rx_enabled),
        .tx_enabled(tx_enabled), .glob_rst_stb(glob_rst_stb), .rx_rst_stb(rx_rst_stb),
        .tx_rst_stb(tx_rst_stb), .fwd_stb(fwd_stb), .fwd_op(fwd_op), .fwd_arg(fwd_arg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        cmd_we = 1; cmd_word = w;
        @(negedge clk);
        cmd_we = 0; cmd_word = 0;
    endtask

    task automatic pulse(input logic [5:0] e);
        {ev_stats, ev_rx_early, ev_rx_done, ev_tx_room, ev_tx_done, ev_fail} = e;
        @(negedge clk);
        {ev_stats, ev_rx_early, ev_rx_done, ev_tx_room, ev_tx_done, ev_fail} = '0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int busy_n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R7 reset state", {status_word, irq, rx_enabled, tx_enabled}, {16'h0000, 3'b000});

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][34:19]);
            @(negedge clk);
            check($sformatf("R1-vector %0d status", i), status_word, VEC[i][18:3]);
            check($sformatf("R5 vector %0d irq/en", i), {irq, rx_enabled, tx_enabled}, VEC[i][2:0]);
        end

        // R3: event positions (enable mask is 0x40, so no latch)
        pulse(6'b000001);
        check("R3 failure bit", status_word, 16'h6002);
        pulse(6'b111111);
        check("R3 all events", {status_word, irq}, {16'h60BE, 1'b0});
        send(16'h68FF);
        check("R4 ack all", status_word, 16'h6000);

        // R10: event and ack of bit4 in the same cycle
        send(16'h7010);
        ev_rx_done = 1; cmd_we = 1; cmd_word = 16'h6810;
        @(negedge clk);
        ev_rx_done = 0; cmd_we = 0; cmd_word = 0;
        check("R10 event beats ack", {status_word, irq}, {16'h6011, 1'b1});
        send(16'h6811);
        check("R5 latch cleared", {status_word, irq}, {16'h6000, 1'b0});

        // R11: forwarded opcode
        send(16'h800F);
        check("R11 forward strobe", {fwd_stb, fwd_op, fwd_arg}, {1'b1, 5'h10, 11'h00F});
        @(negedge clk);
        check("R11 strobe one cycle", fwd_stb, 1'b0);

        // R8 R9: rx reset, busy window, command dropped
        send(16'h2000);
        send(16'h2800);
        check("R8 rx reset strobe", {rx_rst_stb, status_word[12], rx_enabled}, 3'b110);
        busy_n = 1;
        send(16'h0801);
        while (status_word[12] && busy_n < 50) begin
            busy_n++;
            @(negedge clk);
        end
        check("R8 busy length", busy_n, BUSY);
        check("R9 window unchanged", status_word[15:13], 3'd3);

        // R8 global reset
        send(16'h7840);
        send(16'h6000);
        send(16'h0000);
        check("R8 global strobe", glob_rst_stb, 1'b1);
        repeat (BUSY) @(negedge clk);
        check("R8 global state", {status_word, irq, rx_enabled, tx_enabled}, {16'h0000, 3'b000});
        send(16'h6000);
        check("R6 R8 masks reset", {status_word, irq}, {16'h0040, 1'b0});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule